// File: doc/BRIEF.md
# IOMMU Translation Context Register Bank

This block holds the software-visible state of a small address-translation unit that supports up to eight independent translation contexts. Each context owns a control word, translation-control and bus-control words, two 64-bit table base pointers split into low and high halves, two memory-attribute words, a fault status word and a fault address word. Software reaches all of them through a plain 32-bit register port with a 12-bit byte address. The same bank also answers at a second window 0x800 higher.

Two pieces of state are owned by hardware. First, the TLB flush bit in the control word is a busy flag. Software sets it, the block raises a per-context flush request toward the external TLB, and the bit drops by itself when the TLB returns a done pulse. If translation is off in that context, the bit drops on the next cycle. Second, the status and fault address words record the first fault that an external translation engine reports for a context. They hold that record until software writes zero to status, which also wipes the fault address. A single interrupt line combines all contexts whose interrupt enable is set and that hold a fault.

Top module: `xlat_ctx_bank`

## Requirements
- R1: After reset, every register of every context reads 0, and `irq`, `xlat_en` and `flush_req` are all low.
- R2: Address bits 10:6 select the context, so context k starts at k×0x40. Within a context the word offsets are:
  - control 0x00
  - translation control 0x08
  - bus control 0x0C
  - table base 0x10/0x14/0x18/0x1C
  - status 0x20
  - attributes 0x28/0x2C
  - fault address 0x30

  The translation-control, bus-control, table-base and attribute words read back the last value written, separately for each context.
- R3: Address bit 11 is ignored, so an access at address+0x800 reaches the same register as the access at the address itself.
- R4: In the control word, bit 0 enables translation and drives `xlat_en[k]`, and bit 2 enables interrupts. Every other control bit reads 0, except the flush bit.
- R5: Writing the control word with bit 1 set starts a flush. Bit 1 then reads 1, and `flush_req[k]` is high while translation is enabled. Both stay that way, even across control writes with bit 1 clear, until a `flush_done[k]` pulse arrives. They read 0 from the cycle after that pulse.
- R6: A flush started while translation is disabled shows bit 1 as 1 for exactly one cycle, then clears. `flush_req[k]` stays low throughout.
- R7: A fault event (`flt_valid` with `flt_ctx`) records the fault flags, error code and error level in the status word, and records `flt_addr` in the fault address word.
  - Fault flags map from `flt_flags` bits 0..3 (translation fault, page fault, walk abort, multiple hit) to status bits 0, 1, 2 and 4.
  - The error code (`flt_code`: 1 table format, 4 access permission, 5 secure access) goes to status bits 10:8.
  - The error level goes to status bits 13:12.
  - An event with all four flags clear is ignored.
- R8: A fault event for a context that already shows any fault flag is ignored. The status and address of the first fault are kept.
- R9: Writing zero to status clears all status fields and the fault address. A non-zero write to status has no effect. A fault event in the same cycle as a zero write is recorded.
- R10: `irq` is high exactly when some context has its interrupt enable set and at least one fault flag set.
- R11: An access to a context index at or above `NUM_CTX`, or to an undefined offset, reads 0 and its write is ignored. A fault event naming such a context is ignored.
- R12: The fault address word is read-only, so writes to it leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| flt_valid | input | 1 | Fault event strobe from the translation engine |
| flt_ctx | input | 5 | Context index of the fault event |
| flt_flags | input | 4 | Fault kind: translation, page, walk abort, multiple hit |
| flt_code | input | 3 | Error code of the fault |
| flt_level | input | 2 | Table level of the fault |
| flt_addr | input | 32 | Faulting input address |
| flush_done | input | NUM_CTX | Per-context TLB invalidation complete pulse |
| flush_req | output | NUM_CTX | Per-context TLB invalidation request |
| xlat_en | output | NUM_CTX | Per-context translation enable |
| irq | output | 1 | Combined fault interrupt |

## Verification
Two events can meet in one cycle: the engine reporting a new fault, and software clearing status with a zero write to the same context. The bench provokes this by driving both the strobe and the write on the same clock edge to a context that already holds a fault. It then judges the result by reading back status and fault address: they must show the new event, not zero and not the old record. The flush handshake has a similar meeting point. A flush on a disabled context is sampled once in the single cycle where the busy bit is visible, and once after it has dropped.

// File: rtl/xlat_ctx_pkg.sv
`timescale 1ns/1ps
// Shared constants, register selector type and helpers for the context bank.
// Assumes a 12-bit byte address: bit 11 is the alias, bits 10:6 the context.
package xlat_ctx_pkg;
    localparam int BANK_AW   = 12;
    localparam int ALIAS_BIT = 11;
    localparam int IDX_LSB   = 6;
    localparam int IDX_W     = ALIAS_BIT - IDX_LSB;
    localparam int OFF_LSB   = 2;
    localparam int OFF_W     = IDX_LSB - OFF_LSB;
    localparam int MAX_CTX   = 8;
    localparam int STORE_N   = 8;
    localparam int FLAG_W    = 4;

    // Word offsets (byte offset / 4) inside a context window.
    localparam logic [OFF_W-1:0] W_CTL   = 4'h0;
    localparam logic [OFF_W-1:0] W_TCR   = 4'h2;
    localparam logic [OFF_W-1:0] W_BUS   = 4'h3;
    localparam logic [OFF_W-1:0] W_TB0L  = 4'h4;
    localparam logic [OFF_W-1:0] W_TB0H  = 4'h5;
    localparam logic [OFF_W-1:0] W_TB1L  = 4'h6;
    localparam logic [OFF_W-1:0] W_TB1H  = 4'h7;
    localparam logic [OFF_W-1:0] W_STAT  = 4'h8;
    localparam logic [OFF_W-1:0] W_ATTR0 = 4'hA;
    localparam logic [OFF_W-1:0] W_ATTR1 = 4'hB;
    localparam logic [OFF_W-1:0] W_FAR   = 4'hC;

    typedef enum logic [3:0] {
        SEL_CTL, SEL_TCR, SEL_BUS, SEL_TB0L, SEL_TB0H, SEL_TB1L,
        SEL_TB1H, SEL_STAT, SEL_ATTR0, SEL_ATTR1, SEL_FAR, SEL_NONE
    } reg_sel_e;

    // Map a word offset onto a register selector.
    function automatic reg_sel_e decode_word(input logic [OFF_W-1:0] w);
        case (w)
            W_CTL:   return SEL_CTL;
            W_TCR:   return SEL_TCR;
            W_BUS:   return SEL_BUS;
            W_TB0L:  return SEL_TB0L;
            W_TB0H:  return SEL_TB0H;
            W_TB1L:  return SEL_TB1L;
            W_TB1H:  return SEL_TB1H;
            W_STAT:  return SEL_STAT;
            W_ATTR0: return SEL_ATTR0;
            W_ATTR1: return SEL_ATTR1;
            W_FAR:   return SEL_FAR;
            default: return SEL_NONE;
        endcase
    endfunction

    // True for the plain read/write storage words.
    function automatic logic is_store(input reg_sel_e s);
        return (s == SEL_TCR) || (s == SEL_BUS) || (s == SEL_TB0L) ||
               (s == SEL_TB0H) || (s == SEL_TB1L) || (s == SEL_TB1H) ||
               (s == SEL_ATTR0) || (s == SEL_ATTR1);
    endfunction

    // Slot in the storage array for a storage word.
    function automatic logic [2:0] store_slot(input reg_sel_e s);
        case (s)
            SEL_TCR:   return 3'd0;
            SEL_BUS:   return 3'd1;
            SEL_TB0L:  return 3'd2;
            SEL_TB0H:  return 3'd3;
            SEL_TB1L:  return 3'd4;
            SEL_TB1H:  return 3'd5;
            SEL_ATTR0: return 3'd6;
            default:   return 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/xlat_ctx_dec.sv
`timescale 1ns/1ps
// Address decoder: splits a bank byte address into context index and
// register selector, and flags whether the access lands on real state.
// Assumes the alias bit and the two byte-lane bits carry no meaning.
module xlat_ctx_dec
    import xlat_ctx_pkg::*;
#(
    parameter int NUM_CTX = 8
) (
    input  logic [BANK_AW-1:0] addr,
    output logic [IDX_W-1:0]   idx,
    output reg_sel_e           sel,
    output logic               hit
);
    // Field extraction and implemented-context check.
    always_comb begin
        idx = addr[ALIAS_BIT-1:IDX_LSB];
        sel = decode_word(addr[IDX_LSB-1:OFF_LSB]);
        hit = (32'(idx) < NUM_CTX) && (sel != SEL_NONE);
    end
endmodule

// File: rtl/xlat_ctx_unit.sv
`timescale 1ns/1ps
// One translation context: control bits, flush busy flag, storage words,
// fault record and interrupt request. Assumes wr_en and flt_in already
// qualified for this context; rdata follows sel combinationally.
module xlat_ctx_unit
    import xlat_ctx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  reg_sel_e          rd_sel,
    input  logic [DW-1:0]     wdata,
    input  logic              flt_in,
    input  logic [FLAG_W-1:0] flt_flags,
    input  logic [2:0]        flt_code,
    input  logic [1:0]        flt_level,
    input  logic [DW-1:0]     flt_addr,
    input  logic              flush_done,
    output logic [DW-1:0]     rdata,
    output logic              xlat_en,
    output logic              flush_req,
    output logic              irq_req,
    output logic [FLAG_W-1:0] flags_o,
    output logic [DW-1:0]     far_o,
    output logic              busy_o
);
    logic              en_q, ie_q, busy_q;
    logic [FLAG_W-1:0] flg_q;
    logic [2:0]        code_q;
    logic [1:0]        lvl_q;
    logic [DW-1:0]     far_q;
    logic [DW-1:0]     store_q [STORE_N];
    logic              wr_ctl, wr_stat, stat_clr, flt_take, wr_store;
    logic [2:0]        wslot, rslot;
    logic [DW-1:0]     stat_word;

    // Write qualification and fault acceptance.
    always_comb begin
        wr_ctl   = wr_en && (wr_sel == SEL_CTL);
        wr_stat  = wr_en && (wr_sel == SEL_STAT);
        stat_clr = wr_stat && (wdata == '0);
        flt_take = flt_in && (flt_flags != '0) && (stat_clr || (flg_q == '0));
        wr_store = wr_en && is_store(wr_sel);
        wslot    = store_slot(wr_sel);
        rslot    = store_slot(rd_sel);
    end

    // Control enables written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            ie_q <= 1'b0;
        end else if (wr_ctl) begin
            en_q <= wdata[0];
            ie_q <= wdata[2];
        end
    end

    // Flush busy flag: set by software, cleared by done or idle translation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (wr_ctl && wdata[1]) begin
            busy_q <= 1'b1;
        end else if (busy_q && (flush_done || !en_q)) begin
            busy_q <= 1'b0;
        end
    end

    // Fault record: first fault wins, a zero write to status wipes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q  <= '0;
            code_q <= '0;
            lvl_q  <= '0;
            far_q  <= '0;
        end else if (flt_take) begin
            flg_q  <= flt_flags;
            code_q <= flt_code;
            lvl_q  <= flt_level;
            far_q  <= flt_addr;
        end else if (stat_clr) begin
            flg_q  <= '0;
            code_q <= '0;
            lvl_q  <= '0;
            far_q  <= '0;
        end
    end

    // Plain storage words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STORE_N; k++) store_q[k] <= '0;
        end else if (wr_store) begin
            store_q[wslot] <= wdata;
        end
    end

    // Status word packing: flags in 4,2,1,0, code in 10:8, level in 13:12.
    always_comb begin
        stat_word        = '0;
        stat_word[0]     = flg_q[0];
        stat_word[1]     = flg_q[1];
        stat_word[2]     = flg_q[2];
        stat_word[4]     = flg_q[3];
        stat_word[10:8]  = code_q;
        stat_word[13:12] = lvl_q;
    end

    // Read data selection.
    always_comb begin
        case (rd_sel)
            SEL_CTL:  rdata = DW'({ie_q, busy_q, en_q});
            SEL_STAT: rdata = stat_word;
            SEL_FAR:  rdata = far_q;
            SEL_NONE: rdata = '0;
            default:  rdata = store_q[rslot];
        endcase
    end

    // Outputs toward the TLB, the interrupt combiner and the checker.
    always_comb begin
        xlat_en   = en_q;
        flush_req = busy_q && en_q;
        irq_req   = ie_q && (flg_q != '0);
        flags_o   = flg_q;
        far_o     = far_q;
        busy_o    = busy_q;
    end
endmodule

// File: rtl/xlat_ctx_bank.sv
`timescale 1ns/1ps
// Translation context register bank: NUM_CTX context units behind one
// register port, per-context flush handshake, fault capture and a single
// combined interrupt. Assumes NUM_CTX is between 1 and MAX_CTX and at most
// one fault event per cycle.
module xlat_ctx_bank
    import xlat_ctx_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [BANK_AW-1:0] reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic               flt_valid,
    input  logic [IDX_W-1:0]   flt_ctx,
    input  logic [FLAG_W-1:0]  flt_flags,
    input  logic [2:0]         flt_code,
    input  logic [1:0]         flt_level,
    input  logic [DW-1:0]      flt_addr,
    input  logic [NUM_CTX-1:0] flush_done,
    output logic [NUM_CTX-1:0] flush_req,
    output logic [NUM_CTX-1:0] xlat_en,
    output logic               irq
);
    logic [IDX_W-1:0]                dec_idx;
    reg_sel_e                        dec_sel;
    logic                            dec_hit;
    logic [NUM_CTX-1:0][DW-1:0]      ctx_rdata;
    logic [NUM_CTX-1:0][FLAG_W-1:0]  ctx_flags;
    logic [NUM_CTX-1:0][DW-1:0]      ctx_far;
    logic [NUM_CTX-1:0]              ctx_busy;
    logic [NUM_CTX-1:0]              ctx_irq;

    xlat_ctx_dec #(.NUM_CTX(NUM_CTX)) dec_i (
        .addr (reg_addr),
        .idx  (dec_idx),
        .sel  (dec_sel),
        .hit  (dec_hit)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        logic sel_me;
        logic flt_me;
        // Per-context qualification of the write and of the fault event.
        always_comb begin
            sel_me = dec_hit && (dec_idx == IDX_W'(g));
            flt_me = flt_valid && (flt_ctx == IDX_W'(g));
        end

        xlat_ctx_unit #(.DW(DW)) unit_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_wr_en && sel_me),
            .wr_sel     (dec_sel),
            .rd_sel     (dec_sel),
            .wdata      (reg_wdata),
            .flt_in     (flt_me),
            .flt_flags  (flt_flags),
            .flt_code   (flt_code),
            .flt_level  (flt_level),
            .flt_addr   (flt_addr),
            .flush_done (flush_done[g]),
            .rdata      (ctx_rdata[g]),
            .xlat_en    (xlat_en[g]),
            .flush_req  (flush_req[g]),
            .irq_req    (ctx_irq[g]),
            .flags_o    (ctx_flags[g]),
            .far_o      (ctx_far[g]),
            .busy_o     (ctx_busy[g])
        );
    end

    // Read mux: only a decoded, implemented context drives read data.
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_CTX; k++) begin
            if (dec_hit && (dec_idx == IDX_W'(k))) reg_rdata = ctx_rdata[k];
        end
    end

    // Interrupt combiner.
    always_comb irq = |ctx_irq;
endmodule

// File: rtl/xlat_ctx_bank_chk.sv
`timescale 1ns/1ps
// Property checker for the context bank; decodes the register port on its
// own and watches per-context fault, flush and interrupt state.
module xlat_ctx_bank_chk
    import xlat_ctx_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int DW      = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           reg_wr_en,
    input logic [BANK_AW-1:0]             reg_addr,
    input logic [DW-1:0]                  reg_wdata,
    input logic [DW-1:0]                  reg_rdata,
    input logic                           flt_valid,
    input logic [IDX_W-1:0]               flt_ctx,
    input logic [NUM_CTX-1:0]             flush_done,
    input logic [NUM_CTX-1:0]             xlat_en,
    input logic                           irq,
    input logic [NUM_CTX-1:0][FLAG_W-1:0] ctx_flags,
    input logic [NUM_CTX-1:0][DW-1:0]     ctx_far,
    input logic [NUM_CTX-1:0]             ctx_busy
);
    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_word;
    always_comb begin
        a_idx  = reg_addr[ALIAS_BIT-1:IDX_LSB];
        a_word = reg_addr[IDX_LSB-1:OFF_LSB];
    end

    // R11: unimplemented contexts read as zero.
    a_r11_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(a_idx) >= NUM_CTX) |-> (reg_rdata == '0));

    // R10: a rising interrupt follows a fault event or a register write.
    a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(flt_valid || reg_wr_en));

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_chk
        logic stat_zero_wr, ctl_flush_wr, flt_here;
        always_comb begin
            stat_zero_wr = reg_wr_en && (a_idx == IDX_W'(g)) &&
                           (a_word == W_STAT) && (reg_wdata == '0);
            ctl_flush_wr = reg_wr_en && (a_idx == IDX_W'(g)) &&
                           (a_word == W_CTL) && reg_wdata[1];
            flt_here     = flt_valid && (flt_ctx == IDX_W'(g));
        end

        // R8: a held fault record stays put until software clears it.
        a_r8_first_fault_kept: assert property (@(posedge clk) disable iff (!rst_n)
            ((ctx_flags[g] != '0) && !stat_zero_wr) |=>
                ($stable(ctx_far[g]) && $stable(ctx_flags[g])));

        // R9: a zero status write with no competing event empties the record.
        a_r9_zero_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_zero_wr && !flt_here) |=> ((ctx_flags[g] == '0) && (ctx_far[g] == '0)));

        // R6: a flush on a disabled context is gone one cycle later.
        a_r6_idle_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (ctx_busy[g] && !xlat_en[g] && !ctl_flush_wr) |=> !ctx_busy[g]);

        // R5: an active flush waits for the done pulse.
        a_r5_flush_waits_done: assert property (@(posedge clk) disable iff (!rst_n)
            (ctx_busy[g] && xlat_en[g] && !flush_done[g]) |=> ctx_busy[g]);
    end
endmodule

bind xlat_ctx_bank xlat_ctx_bank_chk #(.NUM_CTX(NUM_CTX), .DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .flt_valid  (flt_valid),
    .flt_ctx    (flt_ctx),
    .flush_done (flush_done),
    .xlat_en    (xlat_en),
    .irq        (irq),
    .ctx_flags  (ctx_flags),
    .ctx_far    (ctx_far),
    .ctx_busy   (ctx_busy)
);

// File: tb/xlat_ctx_bank_tb_top.sv
`timescale 1ns/1ps
// Bench: table-driven storage/alias checks, then directed tests.
module xlat_ctx_bank_tb_top;
    localparam int NC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flt_valid = 1'b0;
    logic [4:0]  flt_ctx = '0;
    logic [3:0]  flt_flags = '0;
    logic [2:0]  flt_code = '0;
    logic [1:0]  flt_level = '0;
    logic [31:0] flt_addr = '0;
    logic [NC-1:0] flush_done = '0;
    logic [NC-1:0] flush_req;
    logic [NC-1:0] xlat_en;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xlat_ctx_bank #(.NUM_CTX(NC), .DW(32)) dut_i (
        .clk, .rst_n, .reg_wr_en, .reg_addr, .reg_wdata, .reg_rdata,
        .flt_valid, .flt_ctx, .flt_flags, .flt_code, .flt_level, .flt_addr,
        .flush_done, .flush_req, .xlat_en, .irq
    );

    typedef struct packed {
        logic [11:0] waddr;
        logic [11:0] raddr;
        logic [31:0] data;
    } vec_t;

    // R2/R3 storage vectors: write address, read-back address, value.
    localparam vec_t VECS [10] = '{
        '{12'h008, 12'h008, 32'h8000_3510},
        '{12'h04C, 12'h04C, 32'h0000_0007},
        '{12'h090, 12'h890, 32'hCAFE_1000},
        '{12'h0D4, 12'h0D4, 32'h0000_00AB},
        '{12'h118, 12'h118, 32'h1234_5000},
        '{12'h15C, 12'h95C, 32'h0000_0055},
        '{12'h9A8, 12'h1A8, 32'h0004_44FF},
        '{12'h1EC, 12'h1EC, 32'hA5A5_5A5A},
        '{12'h828, 12'h028, 32'h0102_0304},
        '{12'h048, 12'h048, 32'h8000_2222}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [31:0] rd(input logic [11:0] a);
        reg_addr = a;
        return 32'h0;
    endfunction

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic fault(input logic [4:0] c, input logic [3:0] f, input logic [2:0] code,
                         input logic [1:0] lvl, input logic [31:0] ad);
        @(negedge clk);
        flt_valid = 1'b1; flt_ctx = c; flt_flags = f; flt_code = code;
        flt_level = lvl; flt_addr = ad;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdchk("R1 ctl", 12'h000, 32'h0);
        rdchk("R1 tcr", 12'h1C8, 32'h0);
        rdchk("R1 stat", 12'h0A0, 32'h0);
        rdchk("R1 far", 12'h1F0, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 flush_req", 32'(flush_req), 32'h0);
        check("R1 xlat_en", 32'(xlat_en), 32'h0);

        // R2/R3 table walk: all writes, then all reads
        foreach (VECS[i]) wr(VECS[i].waddr, VECS[i].data);
        foreach (VECS[i]) rdchk("R2/R3 storage", VECS[i].raddr, VECS[i].data);

        // R4 control bits
        wr(12'h080, 32'hFFFF_FFF5);
        rdchk("R4 ctl readback", 12'h080, 32'h5);
        check("R4 xlat_en", 32'(xlat_en), 32'h4);
        wr(12'h080, 32'h0);
        check("R4 xlat_en off", 32'(xlat_en), 32'h0);

        // R5 flush with translation on
        wr(12'h080, 32'h1);
        wr(12'h080, 32'h3);
        check("R5 flush_req set", 32'(flush_req), 32'h4);
        repeat (3) @(negedge clk);
        wr(12'h080, 32'h1);
        rdchk("R5 busy held", 12'h080, 32'h3);
        check("R5 flush_req held", 32'(flush_req), 32'h4);
        @(negedge clk); flush_done = 8'h04;
        @(negedge clk); flush_done = 8'h00;
        rdchk("R5 busy cleared", 12'h080, 32'h1);
        check("R5 flush_req cleared", 32'(flush_req), 32'h0);

        // R6 flush with translation off
        wr(12'h0C0, 32'h2);
        rdchk("R6 busy one cycle", 12'h0C0, 32'h2);
        check("R6 no request", 32'(flush_req), 32'h0);
        @(negedge clk);
        rdchk("R6 busy gone", 12'h0C0, 32'h0);

        // R7 capture, R10 irq gated by enable
        fault(5'd1, 4'b0001, 3'd1, 2'd2, 32'hDEAD_0040);
        rdchk("R7 stat tf", 12'h060, 32'h0000_2101);
        rdchk("R7 far", 12'h070, 32'hDEAD_0040);
        check("R10 irq masked", 32'(irq), 32'h0);
        fault(5'd5, 4'b1110, 3'd5, 2'd1, 32'h0000_BEE0);
        rdchk("R7 stat mixed", 12'h160, 32'h0000_1516);
        fault(5'd6, 4'b0000, 3'd4, 2'd3, 32'h1111_1111);
        rdchk("R7 empty event stat", 12'h1A0, 32'h0);
        rdchk("R7 empty event far", 12'h1B0, 32'h0);

        // R8 second fault ignored
        fault(5'd1, 4'b1000, 3'd4, 2'd1, 32'h0BAD_0000);
        rdchk("R8 stat kept", 12'h060, 32'h0000_2101);
        rdchk("R8 far kept", 12'h070, 32'hDEAD_0040);

        // R10 irq on enable
        wr(12'h040, 32'h4);
        check("R10 irq on", 32'(irq), 32'h1);

        // R9 clear semantics
        wr(12'h060, 32'h5);
        rdchk("R9 nonzero write ignored", 12'h060, 32'h0000_2101);
        wr(12'h860, 32'h0);
        rdchk("R9 stat cleared", 12'h060, 32'h0);
        rdchk("R9 far cleared", 12'h070, 32'h0);
        check("R10 irq off", 32'(irq), 32'h0);

        // R9 clear and new fault in the same cycle on context 5
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h160; reg_wdata = 32'h0;
        flt_valid = 1'b1; flt_ctx = 5'd5; flt_flags = 4'b0001; flt_code = 3'd4;
        flt_level = 2'd3; flt_addr = 32'h7777_0004;
        @(negedge clk);
        reg_wr_en = 1'b0; flt_valid = 1'b0;
        rdchk("R9 same-cycle stat", 12'h160, 32'h0000_3401);
        rdchk("R9 same-cycle far", 12'h170, 32'h7777_0004);

        // R12 fault address is read-only
        wr(12'h170, 32'h0);
        rdchk("R12 far after write", 12'h170, 32'h7777_0004);

        // R11 unimplemented contexts and offsets
        wr(12'h308, 32'h1234_5678);
        rdchk("R11 unimpl ctx", 12'h308, 32'h0);
        wr(12'h004, 32'hFFFF_FFFF);
        rdchk("R11 undefined offset", 12'h004, 32'h0);
        wr(12'h034, 32'hFFFF_FFFF);
        rdchk("R11 undefined offset hi", 12'h034, 32'h0);
        fault(5'd12, 4'b0001, 3'd1, 2'd1, 32'h5555_0000);
        rdchk("R11 ctx4 untouched", 12'h120, 32'h0);
        check("R11 irq untouched", 32'(irq), 32'h0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule